// File: doc/BRIEF.md
# Density-Time Masked Vector Executor

This block runs one element-wise integer operation (add, subtract, and, xor) over two source vectors, but only on the elements whose mask bit is set. It does not step through every element and suppress the writes of the masked-off ones. It keeps a set of pending elements and uses a priority scan to pick the lowest pending one each cycle. That element goes into a two-stage functional unit, so the run time follows the number of active elements, not the vector length.

The mask lives in a register inside the block. A write port loads it, and a set-all control fills it with ones so that the next operation runs unmasked. A start pulse captures the mask, the operands, the operation and the vector length. Results leave through a destination write port made of an enable, an element index and data. Elements that are not written keep their old destination value.

Top module: `dtm_exec`

## Requirements
- R1: After reset, busy, done and wb_en are low and the mask register holds all ones.
- R2: A cycle with mask_set_all high sets every mask bit. When mask_wr is high in the same cycle, mask_set_all wins.
- R3: A cycle with mask_wr high and mask_set_all low loads mask_in into the mask register.
- R4: A start sampled while busy is low captures the mask register value from before that edge, along with src_a, src_b, op and vlen, and raises busy. A start sampled while busy is high is ignored. Operand changes after the capture have no effect.
- R5: Writebacks come out in strictly ascending index order, at most one per cycle. wb_data is the op result of the captured elements a[i] and b[i], where op encodes 0 add, 1 subtract, 2 and, 3 xor, and element i sits at bits [i*DW +: DW].
- R6: The k-th active element (counting from 0) is written back k+2 clock edges after the start edge.
- R7: done is a one-cycle pulse that arrives m+1 edges after the start edge, where m is the number of active elements. busy falls on that same edge. For m>0 the pulse coincides with the last writeback. For m=0 no writeback occurs.
- R8: Only elements with index below vlen take part. A vlen above VLMAX counts as VLMAX, and vlen 0 selects no element.
- R9: An element whose mask bit is clear produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr | input | 1 | Load mask_in into the mask register |
| mask_in | input | VLMAX | New mask, bit i for element i |
| mask_set_all | input | 1 | Set every mask bit |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 0 add, 1 sub, 2 and, 3 xor |
| vlen | input | clog2(VLMAX+1) | Vector length |
| src_a | input | VLMAX*DW | First source vector |
| src_b | input | VLMAX*DW | Second source vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Destination element write enable |
| wb_idx | output | clog2(VLMAX) | Destination element index |
| wb_data | output | DW | Destination element data |

## Verification
Two things can happen on the same edge: a mask update (set-all, or a load) and the start that samples the mask. The bench provokes this by raising start and mask_set_all together after loading a sparse mask. The run that starts on that edge must write back only the sparse elements, and the following run, with no further mask change, must write back every element below vlen. A second collision happens on the completion edge, where done and the last writeback fall in the same cycle. The scoreboard checks this by requiring the queue to be empty when done is seen, and the done cycle to equal the start cycle plus the active count plus one.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } op_t;
endpackage

// File: rtl/dtm_mask_reg.sv
module dtm_mask_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         set_all,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '1;
        else if (set_all) q <= '1;
        else if (wr)      q <= din;
    end
endmodule

// File: rtl/dtm_scan.sv
module dtm_scan #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |pend;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dtm_fu.sv
module dtm_fu
    import dtm_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_v,
    input  logic [IW-1:0] in_idx,
    input  op_t           in_op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          out_v,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          v;
        logic [IW-1:0] idx;
        op_t           op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } s1_t;

    typedef struct packed {
        logic          v;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } s2_t;

    s1_t s1;
    s2_t s2;
    logic [DW-1:0] res;

    always_comb begin
        case (s1.op)
            OP_ADD:  res = s1.a + s1.b;
            OP_SUB:  res = s1.a - s1.b;
            OP_AND:  res = s1.a & s1.b;
            default: res = s1.a ^ s1.b;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1.v   <= in_v;
            s1.idx <= in_idx;
            s1.op  <= in_op;
            s1.a   <= in_a;
            s1.b   <= in_b;
            s2.v    <= s1.v;
            s2.idx  <= s1.idx;
            s2.data <= res;
        end
    end

    assign out_v    = s2.v;
    assign out_idx  = s2.idx;
    assign out_data = s2.data;
endmodule

// File: rtl/dtm_exec.sv
module dtm_exec
    import dtm_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(VLMAX),
    localparam int LW   = $clog2(VLMAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mask_wr,
    input  logic [VLMAX-1:0]      mask_in,
    input  logic                  mask_set_all,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic [LW-1:0]         vlen,
    input  logic [VLMAX*DW-1:0]   src_a,
    input  logic [VLMAX*DW-1:0]   src_b,
    output logic                  busy,
    output logic                  done,
    output logic                  wb_en,
    output logic [IW-1:0]         wb_idx,
    output logic [DW-1:0]         wb_data
);
    logic [VLMAX-1:0]    mask_q;
    logic [VLMAX-1:0]    len_mask;
    logic [VLMAX-1:0]    pend_q;
    logic [VLMAX*DW-1:0] a_q, b_q;
    op_t                 op_q;
    logic                busy_q, done_q;
    logic                found;
    logic [IW-1:0]       sel_idx;
    logic                issue;

    dtm_mask_reg #(.N(VLMAX)) u_mask (
        .clk(clk), .rst(rst), .wr(mask_wr), .set_all(mask_set_all),
        .din(mask_in), .q(mask_q)
    );

    generate
        for (genvar g = 0; g < VLMAX; g++) begin : g_len
            assign len_mask[g] = (LW'(g) < vlen);
        end
    endgenerate

    dtm_scan #(.N(VLMAX), .IW(IW)) u_scan (
        .pend(pend_q), .found(found), .idx(sel_idx)
    );

    assign issue = busy_q && found;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pend_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            op_q   <= OP_ADD;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    pend_q <= mask_q & len_mask;
                    a_q    <= src_a;
                    b_q    <= src_b;
                    op_q   <= op_t'(op);
                end
            end else if (found) begin
                pend_q[sel_idx] <= 1'b0;
            end else begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    dtm_fu #(.DW(DW), .IW(IW)) u_fu (
        .clk(clk), .rst(rst),
        .in_v(issue), .in_idx(sel_idx), .in_op(op_q),
        .in_a(a_q[sel_idx*DW +: DW]), .in_b(b_q[sel_idx*DW +: DW]),
        .out_v(wb_en), .out_idx(wb_idx), .out_data(wb_data)
    );

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/dtm_exec_chk.sv
module dtm_exec_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          wb_en,
    input logic [IW-1:0] wb_idx,
    input logic          mask_wr,
    input logic          mask_set_all,
    input logic [N-1:0]  mask_in,
    input logic [N-1:0]  mask_q
);
    p_set_all_r2: assert property (@(posedge clk) disable iff (rst)
        $past(mask_set_all) |-> (&mask_q));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        $past(mask_wr && !mask_set_all) |-> (mask_q == $past(mask_in)));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_wb_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (busy || done));

    p_wb_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_en && $past(wb_en)) |-> (wb_idx > $past(wb_idx)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (int'(wb_idx) < N));
endmodule

bind dtm_exec dtm_exec_chk #(.N(VLMAX), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .wb_en(wb_en), .wb_idx(wb_idx), .mask_wr(mask_wr),
    .mask_set_all(mask_set_all), .mask_in(mask_in), .mask_q(mask_q)
);

// File: tb/test_dtm_exec.sv
module test_dtm_exec;
    localparam int N  = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mask_wr = 1'b0;
    logic [N-1:0]    mask_in = '0;
    logic            mask_set_all = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op = 2'd0;
    logic [3:0]      vlen = '0;
    logic [N*DW-1:0] src_a = '0;
    logic [N*DW-1:0] src_b = '0;
    logic            busy, done, wb_en;
    logic [2:0]      wb_idx;
    logic [DW-1:0]   wb_data;

    always #4 clk = ~clk;

    dtm_exec #(.VLMAX(N), .DW(DW)) i_dtm_exec (
        .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_in(mask_in),
        .mask_set_all(mask_set_all), .start(start), .op(op), .vlen(vlen),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_done_cyc = 0;
    int wb_cnt = 0;
    int start_cyc = 0;
    logic done_seen = 1'b0;
    logic [N-1:0] model_mask = '1;
    logic [18:0] sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] alu(input logic [1:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (o)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wb_en) begin
                if (sb.size() == 0) begin
                    check(0, "R9 unexpected writeback", int'(wb_idx), -1);
                end else begin
                    logic [18:0] e;
                    e = sb.pop_front();
                    check(wb_idx == e[18:16], "R5 index order", int'(wb_idx), int'(e[18:16]));
                    check(wb_data == e[15:0], "R5 data", int'(wb_data), int'(e[15:0]));
                    check(cyc == start_cyc + 2 + wb_cnt, "R6 writeback timing", cyc, start_cyc + 2 + wb_cnt);
                end
                wb_cnt++;
            end
            if (done) begin
                done_seen = 1'b1;
                check(cyc == exp_done_cyc, "R7 done timing", cyc, exp_done_cyc);
                check(sb.size() == 0, "R7 done with last writeback", sb.size(), 0);
                check(!busy, "R7 busy falls with done", int'(busy), 0);
            end
        end
    end

    task automatic load_mask(input logic [N-1:0] m, input bit also_set);
        @(negedge clk);
        mask_wr = 1'b1; mask_in = m; mask_set_all = also_set;
        model_mask = also_set ? '1 : m;
        @(negedge clk);
        mask_wr = 1'b0; mask_set_all = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] o, input logic [3:0] vl, input logic [DW-1:0] seed, input bit set_all_now);
        int ve, m, t;
        m = 0;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            src_a[i*DW +: DW] = seed + DW'(i * 16'h0123);
            src_b[i*DW +: DW] = (seed ^ 16'h5a5a) + DW'(i * 16'h0031);
        end
        op = o; vlen = vl; start = 1'b1; mask_set_all = set_all_now;
        ve = (int'(vl) > N) ? N : int'(vl);
        for (int i = 0; i < N; i++) begin
            if (i < ve && model_mask[i]) begin
                sb.push_back({3'(i), alu(o, src_a[i*DW +: DW], src_b[i*DW +: DW])});
                m++;
            end
        end
        start_cyc = cyc + 1;
        exp_done_cyc = cyc + m + 2;
        wb_cnt = 0;
        done_seen = 1'b0;
        if (set_all_now) model_mask = '1;
        @(negedge clk);
        start = 1'b0; mask_set_all = 1'b0;
        check(busy, "R4 busy after start", int'(busy), 1);
        // R4: later operand changes and a start while busy are ignored
        src_a = ~src_a; src_b = ~src_b; op = ~o; vlen = 4'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done_seen && t < 100) begin
            @(negedge clk); #1;
            t++;
        end
        check(done_seen, "R7 done observed", int'(done_seen), 1);
        @(negedge clk); #1;
        check(sb.size() == 0 && !wb_en, "R9 no extra writeback", sb.size(), 0);
        sb.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wb_en, "R1 reset outputs", {busy, done, wb_en}, 0);
        run_op(2'd0, 4'd8, 16'h1111, 1'b0);           // R1 reset mask all ones
        load_mask(8'hA5, 1'b0);                       // R3
        run_op(2'd1, 4'd8, 16'h2345, 1'b0);           // R5 R9 sparse
        run_op(2'd2, 4'd5, 16'hF0F0, 1'b0);           // R8 partial length
        load_mask(8'h81, 1'b0);
        run_op(2'd3, 4'd12, 16'h0F0F, 1'b0);          // R8 clamp above VLMAX
        run_op(2'd0, 4'd0, 16'h7777, 1'b0);           // R8 zero length
        load_mask(8'h00, 1'b0);
        run_op(2'd0, 4'd8, 16'h4242, 1'b0);           // R7 all-zero mask
        load_mask(8'h05, 1'b0);
        run_op(2'd0, 4'd8, 16'h9999, 1'b1);           // R2 R4 start with set-all
        run_op(2'd1, 4'd8, 16'h3131, 1'b0);           // R2 mask now all ones
        load_mask(8'h3C, 1'b1);                       // R2 set-all beats load
        run_op(2'd3, 4'd8, 16'hABCD, 1'b0);
        load_mask(8'h80, 1'b0);
        run_op(2'd0, 4'd8, 16'hFFFF, 1'b0);           // R6 single top element
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule